// File: doc/BRIEF.md
# Split-Capable Montgomery Modular Multiplier

This block computes the Montgomery product x·y·2^-W mod m for an odd modulus m, where W is the width of the selected operand. One operand width spans the whole array (TOTAL_BITS bits over TOTAL_STAGES slices of equal size). When splitting is allowed, a run-time select code can instead pick only the lower LOW_STAGES slices or only the remaining upper slices. Each of these acts as an independent, shorter multiplier. A caller places the operands on x_in, y_in and m_in, pulses start together with a select code, and collects the result when ready pulses. The caller uses the product both to move a value into the Montgomery domain (multiply by R² mod m) and to move it back out (multiply by 1).

A controller built around named states sequences each job. The states are IDLE, MULT, FIX, WAIT and DONE. A start with a valid code moves IDLE to MULT, and MULT runs one operand bit per cycle. After the last bit, MULT moves to FIX, which does one conditional subtraction of m. FIX moves to WAIT, which pads the job to the latency figure of the array. When the latency counter reaches its end, WAIT moves to DONE. DONE raises ready for one cycle and returns to IDLE. The result register is written on the same clock edge that raises ready.

Top module: `mmul_top`

## Requirements
- R1: While rst is high and after it falls, ready is 0 and result is all zeros until the first job completes.
- R2: With psel = 2'b11 (full width, W = TOTAL_BITS), result equals x_in·y_in·2^-W mod m_in, for odd m_in and x_in, y_in below m_in.
- R3: The result is fully reduced: within its segment it is always below the modulus of that job.
- R4: ready is high exactly in the cycle that follows the clock edge TOTAL_STAGES + 2·(W−1) edges after the edge that sampled the accepted start.
- R5: With psel = 2'b01 and splitting enabled, only bits [LOW_BITS-1:0] of each operand are used (W = LOW_BITS). The upper operand bits have no effect, and result holds the product in bits [LOW_BITS-1:0] with zeros above. LOW_BITS = (TOTAL_BITS/TOTAL_STAGES)·LOW_STAGES.
- R6: With psel = 2'b10 and splitting enabled, only bits [TOTAL_BITS-1:LOW_BITS] of each operand are used (W = TOTAL_BITS−LOW_BITS). The lower operand bits have no effect, and result holds the product in the upper segment with zeros below.
- R7: Multiplying g by R² mod m (R = 2^W) yields g·R mod m, and multiplying that value by 1 yields g again.
- R8: A start that arrives while a job is in progress, including the cycle in which ready is high, is ignored: no extra ready pulse and no change to the pending result.
- R9: A start with psel = 2'b00 is ignored and produces no ready pulse.
- R10: With SPLIT_EN = 0, codes 2'b01 and 2'b10 run as a full-width job with full-width latency.
- R11: ready is a single-cycle pulse.
- R12: result changes only in the cycle in which ready is high and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Job request, sampled when idle |
| psel | input | 2 | Width select: 11 full, 01 lower, 10 upper, 00 none |
| x_in | input | TOTAL_BITS | Multiplicand, captured with start |
| y_in | input | TOTAL_BITS | Multiplier, captured with start |
| m_in | input | TOTAL_BITS | Odd modulus, captured with start |
| result | output | TOTAL_BITS | Reduced Montgomery product, placed in the selected segment |
| ready | output | 1 | One-cycle completion pulse |

## Verification
Completion of one job and a new start request can land in the same cycle. The bench provokes this by holding start high in exactly the cycle where ready is seen, then watching a window longer than any job. It passes only if the pending job's result arrives intact and no second ready pulse follows. The same judgement covers a start issued in the middle of a job, and a start carrying the unused select code.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_FULL,
        MD_LOW,
        MD_HIGH
    } mmul_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MULT,
        ST_FIX,
        ST_WAIT,
        ST_DONE
    } mmul_state_e;

    // Map the two-bit width select onto an operating mode.
    function automatic mmul_mode_e mode_of(input logic [1:0] code, input bit split_en);
        mmul_mode_e m;
        unique case (code)
            2'b11:   m = MD_FULL;
            2'b01:   m = split_en ? MD_LOW  : MD_FULL;
            2'b10:   m = split_en ? MD_HIGH : MD_FULL;
            default: m = MD_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
    import mmul_pkg::*;
#(
    parameter int TOTAL_BITS   = 1536,
    parameter int TOTAL_STAGES = 96,
    parameter int LOW_BITS     = 512,
    parameter int CW           = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  mmul_mode_e mode,
    output logic       load,
    output logic       step,
    output logic       fix,
    output logic       place,
    output logic       ready
);
    localparam logic [CW-1:0] W_FULL   = CW'(TOTAL_BITS);
    localparam logic [CW-1:0] W_LOW    = CW'(LOW_BITS);
    localparam logic [CW-1:0] W_HIGH   = CW'(TOTAL_BITS - LOW_BITS);
    localparam logic [CW-1:0] LAT_FULL = CW'(TOTAL_STAGES + 2 * (TOTAL_BITS - 1));
    localparam logic [CW-1:0] LAT_LOW  = CW'(TOTAL_STAGES + 2 * (LOW_BITS - 1));
    localparam logic [CW-1:0] LAT_HIGH = CW'(TOTAL_STAGES + 2 * (TOTAL_BITS - LOW_BITS - 1));

    mmul_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, width_q, lat_q;
    logic          accept;

    assign accept = start && (mode != MD_NONE);

    // State register with the cycle counter and the per-job limits.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            width_q <= '0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (accept) begin
                    unique case (mode)
                        MD_LOW:  begin width_q <= W_LOW;  lat_q <= LAT_LOW;  end
                        MD_HIGH: begin width_q <= W_HIGH; lat_q <= LAT_HIGH; end
                        default: begin width_q <= W_FULL; lat_q <= LAT_FULL; end
                    endcase
                end
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_MULT;
            ST_MULT: if (cnt_q == width_q - CW'(1)) state_d = ST_FIX;
            ST_FIX:  state_d = ST_WAIT;
            ST_WAIT: if (cnt_q == lat_q - CW'(1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        load  = 1'b0;
        step  = 1'b0;
        fix   = 1'b0;
        place = 1'b0;
        ready = 1'b0;
        unique case (state_q)
            ST_IDLE: load  = accept;
            ST_MULT: step  = 1'b1;
            ST_FIX:  fix   = 1'b1;
            ST_WAIT: place = (cnt_q == lat_q - CW'(1));
            ST_DONE: ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mmul_datapath.sv
module mmul_datapath
    import mmul_pkg::*;
#(
    parameter int TOTAL_BITS = 1536,
    parameter int LOW_BITS   = 512
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  step,
    input  logic                  fix,
    input  logic                  place,
    input  mmul_mode_e            mode,
    input  logic [TOTAL_BITS-1:0] x_in,
    input  logic [TOTAL_BITS-1:0] y_in,
    input  logic [TOTAL_BITS-1:0] m_in,
    output logic [TOTAL_BITS-1:0] result
);
    localparam int TW = TOTAL_BITS + 2;
    localparam logic [TOTAL_BITS-1:0] LOW_MASK =
        {{(TOTAL_BITS - LOW_BITS){1'b0}}, {LOW_BITS{1'b1}}};

    logic [TOTAL_BITS-1:0] xs_q, ys_q, ms_q, res_q;
    logic [TW-1:0]         acc_q, sum_a, sum_b;
    mmul_mode_e            mode_q;

    // Bring the selected segment down to bit 0.
    function automatic logic [TOTAL_BITS-1:0] align(input logic [TOTAL_BITS-1:0] v,
                                                    input mmul_mode_e md);
        unique case (md)
            MD_LOW:  return v & LOW_MASK;
            MD_HIGH: return v >> LOW_BITS;
            default: return v;
        endcase
    endfunction

    // One radix-2 reduction step: add y if the current x bit is set,
    // make the sum even with m, halve.
    always_comb begin
        sum_a = acc_q + (xs_q[0] ? {2'b00, ys_q} : '0);
        sum_b = sum_a[0] ? sum_a + {2'b00, ms_q} : sum_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xs_q   <= '0;
            ys_q   <= '0;
            ms_q   <= '0;
            acc_q  <= '0;
            res_q  <= '0;
            mode_q <= MD_NONE;
        end else begin
            if (load) begin
                xs_q   <= align(x_in, mode);
                ys_q   <= align(y_in, mode);
                ms_q   <= align(m_in, mode);
                acc_q  <= '0;
                mode_q <= mode;
            end else if (step) begin
                xs_q  <= xs_q >> 1;
                acc_q <= sum_b >> 1;
            end else if (fix) begin
                if (acc_q >= {2'b00, ms_q})
                    acc_q <= acc_q - {2'b00, ms_q};
            end
            if (place) begin
                unique case (mode_q)
                    MD_LOW:  res_q <= acc_q[TOTAL_BITS-1:0] & LOW_MASK;
                    MD_HIGH: res_q <= acc_q[TOTAL_BITS-1:0] << LOW_BITS;
                    default: res_q <= acc_q[TOTAL_BITS-1:0];
                endcase
            end
        end
    end

    assign result = res_q;

endmodule

// File: rtl/mmul_top.sv
module mmul_top
    import mmul_pkg::*;
#(
    parameter int TOTAL_BITS   = 1536,
    parameter int TOTAL_STAGES = 96,
    parameter int LOW_STAGES   = 32,
    parameter bit SPLIT_EN     = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            psel,
    input  logic [TOTAL_BITS-1:0] x_in,
    input  logic [TOTAL_BITS-1:0] y_in,
    input  logic [TOTAL_BITS-1:0] m_in,
    output logic [TOTAL_BITS-1:0] result,
    output logic                  ready
);
    localparam int SLICE_BITS = TOTAL_BITS / TOTAL_STAGES;
    localparam int LOW_BITS   = SLICE_BITS * LOW_STAGES;
    localparam int CW         = $clog2(TOTAL_STAGES + 2 * TOTAL_BITS + 1);

    mmul_mode_e mode;
    logic       load, step, fix, place;

    assign mode = mode_of(psel, SPLIT_EN);

    mmul_ctrl #(
        .TOTAL_BITS  (TOTAL_BITS),
        .TOTAL_STAGES(TOTAL_STAGES),
        .LOW_BITS    (LOW_BITS),
        .CW          (CW)
    ) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .mode (mode),
        .load (load),
        .step (step),
        .fix  (fix),
        .place(place),
        .ready(ready)
    );

    mmul_datapath #(
        .TOTAL_BITS(TOTAL_BITS),
        .LOW_BITS  (LOW_BITS)
    ) u_dp (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .place (place),
        .mode  (mode),
        .x_in  (x_in),
        .y_in  (y_in),
        .m_in  (m_in),
        .result(result)
    );

endmodule

// File: rtl/mmul_check.sv
module mmul_check #(
    parameter int TOTAL_BITS   = 1536,
    parameter int LOW_BITS     = 512,
    parameter int TOTAL_STAGES = 96,
    parameter bit SPLIT_EN     = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [1:0]            psel,
    input logic [TOTAL_BITS-1:0] m_in,
    input logic [TOTAL_BITS-1:0] result,
    input logic                  ready
);
    localparam logic [15:0] L_FULL = 16'(TOTAL_STAGES + 2 * (TOTAL_BITS - 1));
    localparam logic [15:0] L_LOW  = 16'(TOTAL_STAGES + 2 * (LOW_BITS - 1));
    localparam logic [15:0] L_HIGH = 16'(TOTAL_STAGES + 2 * (TOTAL_BITS - LOW_BITS - 1));

    logic                  busy;
    logic [15:0]           cnt, lat;
    logic [1:0]            eff, cap;
    logic [TOTAL_BITS-1:0] mcap;

    assign eff = SPLIT_EN ? psel : ((psel != 2'b00) ? 2'b11 : 2'b00);

    // Independent job tracker.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            lat  <= '0;
            cap  <= 2'b00;
            mcap <= '0;
        end else if (ready) begin
            busy <= 1'b0;
        end else if (!busy && start && eff != 2'b00) begin
            busy <= 1'b1;
            cnt  <= '0;
            cap  <= eff;
            mcap <= m_in;
            lat  <= (eff == 2'b01) ? L_LOW : (eff == 2'b10) ? L_HIGH : L_FULL;
        end else if (busy) begin
            cnt <= cnt + 16'd1;
        end
    end

    a_r3_below_modulus: assert property (@(posedge clk) disable iff (rst)
        (ready && cap == 2'b11) |-> (result < mcap));

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        ready |-> (busy && cnt == lat));

    a_r4_not_early: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt < lat) |-> !ready);

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (ready && cap == 2'b01) |-> (result >> LOW_BITS) == '0);

    a_r9_no_spurious_ready: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ready);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r12_result_hold: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(result));

endmodule

bind mmul_top mmul_check #(
    .TOTAL_BITS  (TOTAL_BITS),
    .LOW_BITS    (LOW_BITS),
    .TOTAL_STAGES(TOTAL_STAGES),
    .SPLIT_EN    (SPLIT_EN)
) u_check (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .psel  (psel),
    .m_in  (m_in),
    .result(result),
    .ready (ready)
);

// File: tb/mmul_top_test.sv
module mmul_top_test;
    localparam int NB   = 128;
    localparam int NS   = 8;
    localparam int NLS  = 4;
    localparam int LB   = (NB / NS) * NLS;
    localparam int HB   = NB - LB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    psel = 2'b11;
    logic [NB-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic [NB-1:0] result, result_ns;
    logic          ready, ready_ns;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int ready_count = 0;
    bit done = 1'b0;
    bit prev_ready = 1'b0;
    logic [NB-1:0] last_res = '0;

    logic [NB-1:0] q_res[$];
    int            q_lat[$];
    int            q_cyc[$];
    string         q_tag[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    mmul_top #(.TOTAL_BITS(NB), .TOTAL_STAGES(NS), .LOW_STAGES(NLS), .SPLIT_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .psel(psel),
        .x_in(x_in), .y_in(y_in), .m_in(m_in), .result(result), .ready(ready));

    mmul_top #(.TOTAL_BITS(NB), .TOTAL_STAGES(NS), .LOW_STAGES(NLS), .SPLIT_EN(1'b0)) uut_nosplit (
        .clk(clk), .rst(rst), .start(start), .psel(psel),
        .x_in(x_in), .y_in(y_in), .m_in(m_in), .result(result_ns), .ready(ready_ns));

    task automatic check(input bit ok, input string req, input logic [NB-1:0] act,
                         input logic [NB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: (x*y mod m) * (2^-1 mod m)^w mod m, with 2^-1 = (m+1)/2.
    function automatic logic [NB-1:0] mref(input logic [NB-1:0] x, y, m, input int w);
        logic [2*NB-1:0] mm, p, inv2, ri;
        mm   = {{NB{1'b0}}, m};
        p    = ({{NB{1'b0}}, x} * {{NB{1'b0}}, y}) % mm;
        inv2 = (mm + 1) >> 1;
        ri   = 1;
        for (int i = 0; i < w; i++) ri = (ri * inv2) % mm;
        p = (p * ri) % mm;
        return p[NB-1:0];
    endfunction

    function automatic logic [NB-1:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [NB-1:0] rmod(input int w);
        logic [NB-1:0] v;
        v = rnd();
        if (w < NB) v = v & ((NB'(1) << w) - NB'(1));
        v[w-1] = 1'b1;
        v[0]   = 1'b1;
        return v;
    endfunction

    // Driver: place operands in the segment picked by code, pulse start,
    // push the expectation when the job should be accepted.
    task automatic issue(input logic [1:0] code, input logic [NB-1:0] x, y, m,
                         input logic [NB-1:0] expv, input string tag, input bit accept);
        logic [NB-1:0] junk;
        int w;
        junk = rnd();
        @(negedge clk);
        psel = code;
        unique case (code)
            2'b01: begin
                x_in = {junk[HB-1:0], x[LB-1:0]};
                y_in = {junk[LB-1:0] ^ junk[HB-1:0], y[LB-1:0]};
                m_in = {~junk[HB-1:0], m[LB-1:0]};
                w = LB;
            end
            2'b10: begin
                x_in = {x[HB-1:0], junk[LB-1:0]};
                y_in = {y[HB-1:0], ~junk[LB-1:0]};
                m_in = {m[HB-1:0], junk[LB-1:0] ^ 64'h5a5a};
                w = HB;
            end
            default: begin
                x_in = x; y_in = y; m_in = m;
                w = NB;
            end
        endcase
        start = 1'b1;
        if (accept) begin
            q_cyc.push_back(cyc + 1);
            q_lat.push_back(NS + 2 * (w - 1));
            q_tag.push_back(tag);
            if (code == 2'b01)      q_res.push_back(expv & ((NB'(1) << LB) - NB'(1)));
            else if (code == 2'b10) q_res.push_back(expv << LB);
            else                    q_res.push_back(expv);
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_res.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(result == last_res, "R12", result, last_res);
    endtask

    task automatic run_mode(input logic [1:0] code, input int w, input string tag);
        logic [NB-1:0] m, x, y;
        m = rmod(w);
        x = rnd() % m;
        y = rnd() % m;
        issue(code, x, y, m, mref(x, y, m, w), tag, 1'b1);
        wait_idle();
    endtask

    // Monitor: compare every ready against the oldest expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ready && ready) check(1'b0, "R11", {NB{ready}}, '0);
            if (ready) begin
                ready_count++;
                if (q_res.size() == 0) begin
                    check(1'b0, "R8", result, '0);
                end else begin
                    logic [NB-1:0] e;
                    int lat, c0;
                    string t;
                    e = q_res.pop_front();
                    lat = q_lat.pop_front();
                    c0 = q_cyc.pop_front();
                    t = q_tag.pop_front();
                    check(result == e, t, result, e);
                    check(cyc - c0 == lat, "R4", NB'(cyc - c0), NB'(lat));
                end
                last_res = result;
            end
            prev_ready = ready;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        logic [NB-1:0] m, g, x, y, rm, r2, gr;
        logic [2*NB-1:0] wide;
        int rc0;

        repeat (5) @(negedge clk);
        check(ready == 1'b0 && result == '0, "R1", result, '0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(ready == 1'b0 && result == '0, "R1", result, '0);

        // R2 / R3: random full-width products
        for (int i = 0; i < 3; i++) run_mode(2'b11, NB, "R2");
        // R3 boundaries: zero operand and largest residues
        m = rmod(NB);
        issue(2'b11, '0, rnd() % m, m, '0, "R3", 1'b1);
        wait_idle();
        issue(2'b11, m - 1, m - 1, m, mref(m - 1, m - 1, m, NB), "R3", 1'b1);
        wait_idle();

        // R5 / R6: split segments with junk in the unused segment
        for (int i = 0; i < 2; i++) run_mode(2'b01, LB, "R5");
        for (int i = 0; i < 2; i++) run_mode(2'b10, HB, "R6");

        // R7: into and out of the Montgomery domain
        m  = rmod(NB);
        g  = rnd() % m;
        wide = ({{NB{1'b0}}, 1'b1} << NB) % {{NB{1'b0}}, m};
        rm = wide[NB-1:0];
        wide = ({{NB{1'b0}}, rm} * {{NB{1'b0}}, rm}) % {{NB{1'b0}}, m};
        r2 = wide[NB-1:0];
        wide = ({{NB{1'b0}}, g} * {{NB{1'b0}}, rm}) % {{NB{1'b0}}, m};
        gr = wide[NB-1:0];
        issue(2'b11, g, r2, m, gr, "R7", 1'b1);
        wait_idle();
        issue(2'b11, gr, NB'(1), m, g, "R7", 1'b1);
        wait_idle();

        // R8: start in mid-job and start in the ready cycle
        m = rmod(NB); x = rnd() % m; y = rnd() % m;
        rc0 = ready_count;
        issue(2'b11, x, y, m, mref(x, y, m, NB), "R8", 1'b1);
        repeat (40) @(negedge clk);
        issue(2'b11, y, x ^ 1, m, '0, "R8", 1'b0);
        while (!ready) @(negedge clk);
        start = 1'b1;
        psel  = 2'b11;
        @(negedge clk);
        start = 1'b0;
        repeat (NS + 2 * NB + 40) @(negedge clk);
        check(ready_count == rc0 + 1, "R8", NB'(ready_count - rc0), NB'(1));
        wait_idle();

        // R9: unused code
        rc0 = ready_count;
        issue(2'b00, x, y, m, '0, "R9", 1'b0);
        repeat (NS + 2 * NB + 40) @(negedge clk);
        check(ready_count == rc0, "R9", NB'(ready_count - rc0), '0);
        wait_idle();

        // R10: lower code on both instances; split-disabled one runs full width
        m = rmod(NB); m[LB-1] = 1'b1;
        x = rnd() % m; x[LB-1] = 1'b0;
        y = rnd() % m; y[LB-1] = 1'b0;
        @(negedge clk);
        psel = 2'b01; x_in = x; y_in = y; m_in = m;
        start = 1'b1;
        rc0 = cyc + 1;
        q_cyc.push_back(rc0);
        q_lat.push_back(NS + 2 * (LB - 1));
        q_tag.push_back("R5");
        q_res.push_back(mref(x & ((NB'(1) << LB) - NB'(1)), y & ((NB'(1) << LB) - NB'(1)),
                             m & ((NB'(1) << LB) - NB'(1)), LB));
        @(negedge clk);
        start = 1'b0;
        while (!ready_ns) @(negedge clk);
        check(cyc - rc0 == NS + 2 * (NB - 1), "R10", NB'(cyc - rc0), NB'(NS + 2 * (NB - 1)));
        check(result_ns == mref(x, y, m, NB), "R10", result_ns, mref(x, y, m, NB));
        wait_idle();

        done = 1'b1;
        check(q_res.size() == 0, "R8", NB'(q_res.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule